// File: doc/BRIEF.md
# Serial Flash Page-Program Write Buffer

This block is the write path of a serial NOR flash controller. It owns a 128-byte store that is shared between two uses: in read mode it is reserved for prefetching, and in program mode it collects one flash page. Software selects the mode with one configuration bit and reads that bit back to confirm that the switch has been made. It then sets a flash address through four byte-wide address registers. Next it pushes 32 little-endian words into a single data port. Finally it writes the page-program command code.

For a page program the engine first sends a write-enable opcode in a chip-select frame of its own. It then opens a second frame carrying the page-program opcode, a 3-byte address sent MSB first and all 128 data bytes. The command register shows the running command and returns to zero when the last bit has been shifted. A page tail shorter than 128 bytes goes out through two byte-wide commands. One writes the byte held in the write-data register. The other reads one byte into the read-data register. Both commands step the address by one afterwards. The serial interface is single-bit SPI mode 0.

Top module: `flash_pp_ctrl`

## Requirements
- R1: After reset the command register (offset 0) reads 0, the mode register (offset 1) reads 0, chip select is high and the serial clock is low.
- R2: Writing bit 0 of the mode register (offset 1) requests a mode: 0 is read prefetch and 1 is page-program store. The request takes effect only while no command runs, and reading offset 1 returns the mode that is in effect in bit 0.
- R3: Command code 0x10 sends a one-byte frame holding 0x06. It then sends a separate frame of 132 bytes: 0x02, address bits 23:16, 15:8, 7:0, then the 128 page bytes in rising address order.
- R4: Each word written to the data port (offset 8) carries four page bytes, with bits 7:0 holding the lowest-addressed byte and bits 31:24 the highest.
- R5: The 32-bit address is held in byte registers at offsets 2 (bits 7:0), 3 (bits 15:8), 4 (bits 23:16) and 5 (bits 31:24), and each offset reads back its own byte.
- R6: The command register reads back the running command code until its transfer ends and then reads 0. Codes other than 0x10, 0x90 and 0x81 start nothing.
- R7: Command code 0x90 sends a single frame: 0x02, three address bytes MSB first, then the write-data byte (offset 6).
- R8: Command code 0x81 sends 0x03 and three address bytes, then shifts in one byte on the input line, which becomes readable at offset 7.
- R9: After a 0x90 or 0x81 command completes, the 32-bit address increments by one, carrying across all four bytes and wrapping from 0xFFFFFFFF to 0.
- R10: Command 0x10 issued in read mode sets the error flag (bit 8 of offset 0), starts no frame and leaves the command code at 0.
- R11: Command 0x10 issued before 32 words are held sets the error flag and sends nothing. A completed page program empties the store.
- R12: Words pushed after the store holds 32, or pushed in read mode, are discarded. A mode change empties the store.
- R13: The serial clock is low whenever chip select is high. Output data changes while the clock is low and input data is sampled while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The checks assume that software leaves the address, write-data and mode registers alone while a command is running. The sequencer reads them live, so a write during a transfer would bend the frame contents. The checks also assume that the flash drives its input line only after a falling clock edge. The stimulus waits for the command register to read 0 before it touches any register. It issues each new command only from idle, and the flash model in the bench changes its reply bit only on falling clock edges.

// File: rtl/flash_pp_pkg.sv
package flash_pp_pkg;
  // register offsets
  localparam logic [3:0] A_CMD   = 4'd0;
  localparam logic [3:0] A_MODE  = 4'd1;
  localparam logic [3:0] A_ADDR0 = 4'd2;
  localparam logic [3:0] A_WDAT  = 4'd6;
  localparam logic [3:0] A_RDAT  = 4'd7;
  localparam logic [3:0] A_PUSH  = 4'd8;

  // command codes
  localparam logic [7:0] C_PAGE  = 8'h10;
  localparam logic [7:0] C_BYTEW = 8'h90;
  localparam logic [7:0] C_BYTER = 8'h81;

  // flash opcodes
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;

  typedef enum logic [1:0] {K_PAGE, K_BYTEW, K_BYTER} job_e;
  typedef enum logic [1:0] {S_IDLE, S_WREN, S_GAP, S_XFER} seq_e;
endpackage

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int PAGE_BYTES = 128,
  localparam int WORDS = PAGE_BYTES / 4,
  localparam int CW = $clog2(WORDS + 1),
  localparam int IW = $clog2(PAGE_BYTES),
  localparam int WW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [31:0]   push_word,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [31:0]   mem [WORDS];
  logic [CW-1:0] cnt_q, cnt_n;
  logic          wr_en;
  logic [31:0]   sel_word;

  assign full  = (cnt_q == CW'(WORDS));
  assign wr_en = push && !full && !clr;
  assign count = cnt_q;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)        cnt_n = '0;
    else if (wr_en) cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt_q[WW-1:0]] <= push_word;
  end

  assign sel_word = mem[rd_idx[IW-1:2]];
  assign rd_byte  = 8'(sel_word >> {rd_idx[1:0], 3'b000});
endmodule

// File: rtl/pp_spi_shift.sv
module pp_spi_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic       act_q, act_n;
  logic       ph_q, ph_n;
  logic [2:0] cnt_q, cnt_n;
  logic [7:0] sr_q, sr_n;

  always_comb begin
    act_n = act_q;
    ph_n  = ph_q;
    cnt_n = cnt_q;
    sr_n  = sr_q;
    if (start) begin
      act_n = 1'b1;
      ph_n  = 1'b0;
      cnt_n = 3'd7;
      sr_n  = tx_byte;
    end else if (act_q) begin
      if (!ph_q) begin
        ph_n = 1'b1;
      end else begin
        ph_n = 1'b0;
        sr_n = {sr_q[6:0], miso};
        if (cnt_q == 3'd0) act_n = 1'b0;
        else               cnt_n = cnt_q - 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      act_q <= act_n;
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
    end
  end

  assign sck     = act_q & ph_q;
  assign mosi    = sr_q[7];
  assign done    = act_q & ph_q & (cnt_q == 3'd0);
  assign rx_byte = {sr_q[6:0], miso};
endmodule

// File: rtl/pp_frame_seq.sv
module pp_frame_seq
  import flash_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int GAP_CYC = 2,
  localparam int IW = $clog2(PAGE_BYTES),
  localparam int BW = $clog2(PAGE_BYTES + 4),
  localparam int GW = $clog2(GAP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  job_e          go_job,
  input  logic [23:0]   addr,
  input  logic [7:0]    wbyte,
  input  logic [7:0]    buf_byte,
  output logic [IW-1:0] buf_idx,
  input  logic          sh_done,
  output logic          sh_start,
  output logic [7:0]    sh_tx,
  output logic          cs_n,
  output logic          fin,
  output job_e          job
);
  seq_e          st_q, st_n;
  job_e          job_q, job_n;
  logic [BW-1:0] bidx_q, bidx_n;
  logic [GW-1:0] gap_q, gap_n;
  logic          kick_q, kick_n;
  logic [BW-1:0] last_idx;

  assign last_idx = (job_q == K_PAGE) ? BW'(PAGE_BYTES + 3) : BW'(4);
  assign buf_idx  = IW'(bidx_q - BW'(4));
  assign fin      = (st_q == S_XFER) && sh_done && (bidx_q == last_idx);
  assign sh_start = kick_q;
  assign cs_n     = !((st_q == S_WREN) || (st_q == S_XFER));
  assign job      = job_q;

  always_comb begin
    if (st_q == S_WREN) begin
      sh_tx = OP_WREN;
    end else begin
      case (bidx_q)
        BW'(0):  sh_tx = (job_q == K_BYTER) ? OP_READ : OP_PROG;
        BW'(1):  sh_tx = addr[23:16];
        BW'(2):  sh_tx = addr[15:8];
        BW'(3):  sh_tx = addr[7:0];
        default: sh_tx = (job_q == K_PAGE)  ? buf_byte :
                         (job_q == K_BYTEW) ? wbyte : 8'h00;
      endcase
    end
  end

  always_comb begin
    st_n   = st_q;
    job_n  = job_q;
    bidx_n = bidx_q;
    gap_n  = gap_q;
    kick_n = 1'b0;
    case (st_q)
      S_IDLE: if (go) begin
        job_n  = go_job;
        st_n   = (go_job == K_PAGE) ? S_WREN : S_XFER;
        bidx_n = '0;
        kick_n = 1'b1;
      end
      S_WREN: if (sh_done) begin
        st_n  = S_GAP;
        gap_n = GW'(GAP_CYC - 1);
      end
      S_GAP: begin
        if (gap_q == '0) begin
          st_n   = S_XFER;
          bidx_n = '0;
          kick_n = 1'b1;
        end else begin
          gap_n = gap_q - GW'(1);
        end
      end
      S_XFER: if (sh_done) begin
        if (bidx_q == last_idx) begin
          st_n = S_IDLE;
        end else begin
          bidx_n = bidx_q + BW'(1);
          kick_n = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      job_q  <= K_PAGE;
      bidx_q <= '0;
      gap_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      job_q  <= job_n;
      bidx_q <= bidx_n;
      gap_q  <= gap_n;
      kick_q <= kick_n;
    end
  end
endmodule

// File: rtl/flash_pp_ctrl.sv
module flash_pp_ctrl
  import flash_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int GAP_CYC = 2,
  localparam int WORDS = PAGE_BYTES / 4,
  localparam int CW = $clog2(WORDS + 1),
  localparam int IW = $clog2(PAGE_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic          mode_req_q, mode_req_n, mode_q, mode_n;
  logic          err_q, err_n;
  logic [7:0]    cmd_q, cmd_n;
  logic [31:0]   addr_q, addr_n;
  logic [7:0]    wdat_q, wdat_n, rdat_q, rdat_n;
  logic [CW-1:0] wcnt;
  logic          buf_full, buf_clr, push;
  logic [7:0]    buf_byte;
  logic [IW-1:0] buf_idx;
  logic          sh_start, sh_done;
  logic [7:0]    sh_tx, sh_rx;
  logic          fin, go, cmd_wr, cmd_known, idle, mode_upd;
  job_e          go_job, job;
  logic [3:0]    abyte_we;

  assign idle      = (cmd_q == 8'h00);
  assign cmd_wr    = reg_wr && (reg_addr == A_CMD);
  assign cmd_known = (reg_wdata[7:0] == C_PAGE) || (reg_wdata[7:0] == C_BYTEW) ||
                     (reg_wdata[7:0] == C_BYTER);
  assign go_job    = (reg_wdata[7:0] == C_PAGE)  ? K_PAGE :
                     (reg_wdata[7:0] == C_BYTEW) ? K_BYTEW : K_BYTER;
  assign go        = cmd_wr && idle && cmd_known &&
                     ((go_job != K_PAGE) || (mode_q && buf_full));
  assign mode_upd  = idle && !go;
  assign push      = reg_wr && (reg_addr == A_PUSH) && mode_q;
  assign buf_clr   = (mode_upd && (mode_req_q != mode_q)) || (fin && (job == K_PAGE));

  for (genvar g = 0; g < 4; g++) begin : g_abyte
    assign abyte_we[g] = reg_wr && (reg_addr == (A_ADDR0 + 4'(g)));
  end

  always_comb begin
    mode_req_n = mode_req_q;
    mode_n     = mode_q;
    err_n      = err_q;
    cmd_n      = cmd_q;
    addr_n     = addr_q;
    wdat_n     = wdat_q;
    rdat_n     = rdat_q;
    if (reg_wr && (reg_addr == A_MODE)) mode_req_n = reg_wdata[0];
    if (mode_upd) mode_n = mode_req_q;
    if (reg_wr && (reg_addr == A_WDAT)) wdat_n = reg_wdata[7:0];
    if (cmd_wr && idle && cmd_known) err_n = !go;
    if (go)       cmd_n = reg_wdata[7:0];
    else if (fin) cmd_n = 8'h00;
    for (int i = 0; i < 4; i++) begin
      if (abyte_we[i]) addr_n[8*i +: 8] = reg_wdata[7:0];
    end
    if (fin && (job != K_PAGE)) addr_n = addr_q + 32'd1;
    if (fin && (job == K_BYTER)) rdat_n = sh_rx;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_req_q <= 1'b0;
      mode_q     <= 1'b0;
      err_q      <= 1'b0;
      cmd_q      <= '0;
      addr_q     <= '0;
      wdat_q     <= '0;
      rdat_q     <= '0;
    end else begin
      mode_req_q <= mode_req_n;
      mode_q     <= mode_n;
      err_q      <= err_n;
      cmd_q      <= cmd_n;
      addr_q     <= addr_n;
      wdat_q     <= wdat_n;
      rdat_q     <= rdat_n;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {23'd0, err_q, cmd_q};
      A_MODE:  reg_rdata = {31'd0, mode_q};
      4'd2:    reg_rdata = {24'd0, addr_q[7:0]};
      4'd3:    reg_rdata = {24'd0, addr_q[15:8]};
      4'd4:    reg_rdata = {24'd0, addr_q[23:16]};
      4'd5:    reg_rdata = {24'd0, addr_q[31:24]};
      A_WDAT:  reg_rdata = {24'd0, wdat_q};
      A_RDAT:  reg_rdata = {24'd0, rdat_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  pp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_s_n), .clr(buf_clr), .push(push), .push_word(reg_wdata),
    .rd_idx(buf_idx), .rd_byte(buf_byte), .full(buf_full), .count(wcnt)
  );

  pp_frame_seq #(.PAGE_BYTES(PAGE_BYTES), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .go(go), .go_job(go_job), .addr(addr_q[23:0]),
    .wbyte(wdat_q), .buf_byte(buf_byte), .buf_idx(buf_idx), .sh_done(sh_done),
    .sh_start(sh_start), .sh_tx(sh_tx), .cs_n(spi_cs_n), .fin(fin), .job(job)
  );

  pp_spi_shift u_sh (
    .clk(clk), .rst_n(rst_s_n), .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx_byte(sh_rx)
  );
endmodule

// File: rtl/flash_pp_ctrl_chk.sv
module flash_pp_ctrl_chk #(
  parameter int WORDS = 32,
  localparam int CW = $clog2(WORDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_sck,
  input logic [7:0]    cmd_q,
  input logic          err_q,
  input logic          mode_q,
  input logic [CW-1:0] wcnt
);
  assert_sck_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_frame_in_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> (cmd_q != 8'h00));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 8'h00) |=> ((cmd_q == $past(cmd_q)) || (cmd_q == 8'h00)));

  // covers R10 and R11: a refused start sends nothing
  assert_err_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> spi_cs_n);

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 8'h00) |=> $stable(mode_q));

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(WORDS));
endmodule

bind flash_pp_ctrl flash_pp_ctrl_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .cmd_q(cmd_q), .err_q(err_q), .mode_q(mode_q), .wcnt(wcnt)
);

// File: tb/sim_flash_pp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_pp_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  int errors = 0;
  int checks = 0;

  flash_pp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // flash model: logs every byte and frame length, answers reads
  logic [7:0] log_b [0:299];
  int         flen [0:7];
  int         nb = 0, nf = 0, bitc = 0, fstart = 0;
  logic [7:0] sh_in = 8'h00;
  logic [7:0] rsp = 8'h00;

  initial spi_miso = 1'b0;

  always @(negedge spi_cs_n) begin
    bitc = 0;
    fstart = nb;
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh_in = {sh_in[6:0], spi_mosi};
    bitc++;
    if (bitc % 8 == 0 && nb < 300) begin
      log_b[nb] = sh_in;
      nb++;
    end
  end
  always @(posedge spi_cs_n) begin
    if (nf < 8) flen[nf] = bitc / 8;
    nf++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && nb > fstart && log_b[fstart] == 8'h03) begin
    if (bitc == 32) begin
      rsp = log_b[fstart + 3] ^ 8'h5A;
      spi_miso = rsp[7];
    end else if (bitc > 32) begin
      rsp = {rsp[6:0], 1'b0};
      spi_miso = rsp[7];
    end
  end

  task automatic clr_log();
    nb = 0;
    nf = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      reg_read(4'd0, v);
      if (v[7:0] == 8'h00) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic set_addr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) reg_write(4'(2 + i), {24'd0, a[8*i +: 8]});
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      reg_read(4'(2 + i), v);
      a[8*i +: 8] = v[7:0];
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  // {address, write byte} for single-byte writes
  localparam logic [39:0] BYTEW_TAB [0:3] = '{
    40'h000000FF_3C, 40'h00FFFFFF_A7, 40'hFFFFFFFF_5E, 40'h12345678_01
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int bad;
    reg_wr = 1'b0;
    reg_addr = 4'd0;
    reg_wdata = 32'd0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(4'd0, v); check("R1 cmd", v, 32'h0);
    reg_read(4'd1, v); check("R1 mode", v, 32'h0);
    check("R1 cs_n", {31'd0, spi_cs_n}, 32'h1);
    check("R1 sck", {31'd0, spi_sck}, 32'h0);

    // R7 R9 R5 table of single-byte writes
    for (int k = 0; k < 4; k++) begin
      logic [31:0] ad;
      logic [7:0]  db;
      ad = BYTEW_TAB[k][39:8];
      db = BYTEW_TAB[k][7:0];
      set_addr(ad);
      get_addr(a); check("R5 addr readback", a, ad);
      reg_write(4'd6, {24'd0, db});
      clr_log();
      reg_write(4'd0, 32'h90);
      reg_read(4'd0, v); check("R6 busy code", v, 32'h90);
      wait_idle();
      reg_read(4'd0, v); check("R6 cleared", v, 32'h0);
      check("R7 frames", nf, 1);
      check("R7 length", flen[0], 5);
      check("R7 bytes", {log_b[0], log_b[1], log_b[2], log_b[3]},
            {8'h02, ad[23:16], ad[15:8], ad[7:0]});
      check("R7 data", {24'd0, log_b[4]}, {24'd0, db});
      get_addr(a); check("R9 increment", a, ad + 32'd1);
    end

    // R8 single-byte read
    set_addr(32'h00123456);
    clr_log();
    reg_write(4'd0, 32'h81);
    wait_idle();
    check("R8 frame", {log_b[0], log_b[1], log_b[2], log_b[3]}, 32'h03123456);
    check("R8 length", flen[0], 5);
    reg_read(4'd7, v); check("R8 rdata", v, 32'h56 ^ 32'h5A);
    get_addr(a); check("R9 read increment", a, 32'h00123457);

    // R6 unknown code
    clr_log();
    reg_write(4'd0, 32'h55);
    repeat (20) @(negedge clk);
    reg_read(4'd0, v); check("R6 unknown code", v, 32'h0);
    check("R6 no frame", nf, 0);

    // R10 page program in read mode
    reg_write(4'd8, 32'h11111111);
    clr_log();
    reg_write(4'd0, 32'h10);
    repeat (20) @(negedge clk);
    reg_read(4'd0, v); check("R10 err flag", v, 32'h100);
    check("R10 no frame", nf, 0);

    // R2 switch to program mode
    reg_write(4'd1, 32'h1);
    @(negedge clk);
    reg_read(4'd1, v); check("R2 program mode", v, 32'h1);

    // R11 short page
    for (int w = 0; w < 31; w++)
      reg_write(4'd8, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    clr_log();
    reg_write(4'd0, 32'h10);
    repeat (20) @(negedge clk);
    reg_read(4'd0, v); check("R11 short err", v, 32'h100);
    check("R11 no frame", nf, 0);

    // R3 R4 R12 full page plus one ignored word
    reg_write(4'd8, {pat(127), pat(126), pat(125), pat(124)});
    reg_write(4'd8, 32'hDEADBEEF);
    set_addr(32'h77ABCDEF);
    clr_log();
    reg_write(4'd0, 32'h10);
    reg_read(4'd0, v); check("R6 page busy", v, 32'h10);
    wait_idle();
    reg_read(4'd0, v); check("R3 done err clear", v, 32'h0);
    check("R3 frames", nf, 2);
    check("R3 wren len", flen[0], 1);
    check("R3 wren op", {24'd0, log_b[0]}, 32'h06);
    check("R12 page len", flen[1], 132);
    check("R3 header", {log_b[1], log_b[2], log_b[3], log_b[4]}, 32'h02ABCDEF);
    bad = 0;
    for (int i = 0; i < 128; i++) if (log_b[5 + i] !== pat(i)) bad++;
    check("R4 page bytes", bad, 0);
    get_addr(a); check("R3 addr kept", a, 32'h77ABCDEF);

    // R11 store emptied after page
    clr_log();
    reg_write(4'd0, 32'h10);
    repeat (20) @(negedge clk);
    reg_read(4'd0, v); check("R11 empty after page", v, 32'h100);
    check("R11 no frame again", nf, 0);

    // R2 R12 back to read mode, pushes there are dropped
    reg_write(4'd1, 32'h0);
    @(negedge clk);
    reg_read(4'd1, v); check("R2 read mode", v, 32'h0);
    for (int w = 0; w < 32; w++) reg_write(4'd8, 32'h01020304);
    reg_write(4'd1, 32'h1);
    @(negedge clk);
    clr_log();
    reg_write(4'd0, 32'h10);
    repeat (20) @(negedge clk);
    reg_read(4'd0, v); check("R12 read-mode pushes dropped", v, 32'h100);
    check("R12 no frame", nf, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule